// File: doc/BRIEF.md
# Move-Only Processor Fetch and Decode Sequencer

This block sequences a processor whose single instruction copies a value from one addressed functional unit to another. On every cycle it reads the word at the program counter and sorts it into one of three kinds: an ordinary move, a short inline constant tagged by its top bit, or a reserved prefix that announces a full-width constant in the following word. For each executed transfer it presents the source and destination unit addresses with their subunit codes, the value being moved, and a one-cycle transfer strobe.

The program counter is the only functional unit held inside the block, which makes jumps testable without any other unit. Any executed transfer whose destination is the program-counter unit loads the counter with the moved value, so a jump, a call return or a constant load into the counter is simply a move. Every other cycle advances the counter by one. The source-read bus supplies data for source units other than the constant unit and the program-counter unit. The destination-write bus is made of the destination address, subunit, data and strobe outputs.

Instruction memory is read combinationally: `imem_rdata` must show the word at `imem_addr` within the same cycle.

Top module: `move_decoder`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the program counter is cleared to 0 and the sequencer returns to the fetch state. `move_en` stays low whenever `rst_n` is low.
- R2: An ordinary move word is split as follows: destination unit = bits [7:0], destination subunit = bits [11:8], source unit = bits [19:12], source subunit = bits [23:20], condition match = bits [27:24], condition mask = bits [31:28].
- R3: An ordinary move executes only when `(flags & mask) == (match & mask)`. A zero mask means it always executes. A move that does not execute keeps `move_en` low and advances the counter by one.
- R4: A word with bit 31 set is a short constant. `move_data` is bits [30:0] sign-extended from bit 30. It is moved from source unit 0, subunit 0, to destination unit 0x01, subunit 0, and it executes whatever the flags are.
- R5: The word 0x00000F01, seen in the fetch state, is a long-constant prefix. During that cycle `move_en` stays low and the counter advances by one. In the next cycle the fetched word is moved unchanged to unit 0x01, subunit 0, whatever its bit pattern and whatever the flags are. The sequencer then returns to fetch.
- R6: When an ordinary move names source unit 0 (the constant unit), `move_data` is its source subunit nibble, zero-extended.
- R7: When an ordinary move names source unit 0x01, `move_data` is the current program-counter value.
- R8: For any other source unit, `move_data` equals `src_rdata`.
- R9: An executed transfer to destination unit 0x01 (any subunit) makes the next counter value equal to `move_data`. Every other cycle out of reset advances the counter by one.
- R10: `move_en` is high for exactly one cycle per executed transfer, in the cycle the transfer's word is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| imem_addr | output | 32 | Program counter, used as the instruction memory address |
| imem_rdata | input | 32 | Instruction word at `imem_addr`, same cycle |
| flags | input | 4 | Condition flags compared against each move's mask and match |
| src_unit | output | 8 | Source functional unit address |
| src_sub | output | 4 | Source subunit code |
| src_rdata | input | 32 | Value read from the addressed source unit |
| dst_unit | output | 8 | Destination functional unit address |
| dst_sub | output | 4 | Destination subunit code |
| move_data | output | 32 | Value being transferred |
| move_en | output | 1 | Transfer strobe, one cycle per executed move |

## Verification
The assertions assume that instruction memory answers within the same cycle, so that `imem_rdata` always belongs to the current `imem_addr`. They also assume that `rst_n` is low from the first clock edge, so the counter is known before any property is enabled. The stimulus meets both assumptions. A combinational memory model sits inside the bench, and reset is held for several cycles before being released between clock edges. The flags are held constant for the whole run, so each condition outcome follows from the program alone. The source-read bus is driven as a fixed function of the source address and subunit, which makes every expected transfer value computable ahead of time.

// File: rtl/mvdec_pkg.sv
// Package mvdec_pkg
// Shared widths, reserved unit addresses and the word layout for the
// move-only decoder. Assumes a 32-bit instruction word whose field widths
// add up to WORD_W.
package mvdec_pkg;
    localparam int WORD_W = 32;
    localparam int UNIT_W = 8;
    localparam int SUB_W  = 4;
    localparam int FLAG_W = 4;

    localparam logic [UNIT_W-1:0] UNIT_CONST = 8'h00;
    localparam logic [UNIT_W-1:0] UNIT_PC    = 8'h01;
    localparam logic [SUB_W-1:0]  SUB_ZERO   = '0;
    localparam logic [WORD_W-1:0] LONG_PREFIX = 32'h0000_0F01;

    typedef enum logic [1:0] {
        WK_MOVE   = 2'd0,
        WK_SHORT  = 2'd1,
        WK_PREFIX = 2'd2
    } word_kind_e;

    typedef enum logic {
        SEQ_FETCH = 1'b0,
        SEQ_LONG  = 1'b1
    } seq_state_e;

    // Field order follows the word from bit 31 down to bit 0.
    typedef struct packed {
        logic [FLAG_W-1:0] mask;
        logic [FLAG_W-1:0] match;
        logic [SUB_W-1:0]  src_sub;
        logic [UNIT_W-1:0] src_unit;
        logic [SUB_W-1:0]  dst_sub;
        logic [UNIT_W-1:0] dst_unit;
    } move_fields_t;
endpackage

// File: rtl/mvdec_classify.sv
// Module mvdec_classify
// Sorts a fetched word into move, short constant or long prefix. It also
// splits the move fields and forms the sign-extended short value.
// Assumes the word is the one at the current program counter.
module mvdec_classify
    import mvdec_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    output word_kind_e        kind,
    output move_fields_t      fields,
    output logic [WORD_W-1:0] short_value
);
    localparam int TAG_BIT = WORD_W - 1;

    // Field split is a plain reinterpretation of the word.
    assign fields = move_fields_t'(word);

    // Short constant: drop the tag bit, sign-extend from the bit below it.
    assign short_value = {word[TAG_BIT-1], word[TAG_BIT-1:0]};

    // Kind selection: the tag bit wins, then the exact prefix pattern.
    always_comb begin
        if (word[TAG_BIT]) begin
            kind = WK_SHORT;
        end else if (word == LONG_PREFIX) begin
            kind = WK_PREFIX;
        end else begin
            kind = WK_MOVE;
        end
    end
endmodule

// File: rtl/mvdec_cond.sv
// Module mvdec_cond
// Evaluates a move's condition: every flag bit selected by the mask must
// equal the matching bit of the match nibble. Purely combinational.
module mvdec_cond
    import mvdec_pkg::*;
(
    input  logic [FLAG_W-1:0] flags,
    input  logic [FLAG_W-1:0] mask,
    input  logic [FLAG_W-1:0] match,
    output logic              pass
);
    logic [FLAG_W-1:0] bit_ok;

    // One comparator per flag bit, skipped when its mask bit is clear.
    for (genvar i = 0; i < FLAG_W; i++) begin : g_flag
        assign bit_ok[i] = ~mask[i] | (flags[i] == match[i]);
    end

    assign pass = &bit_ok;
endmodule

// File: rtl/mvdec_src_mux.sv
// Module mvdec_src_mux
// Picks the value an ordinary move carries: the subunit nibble for the
// constant unit, the counter for the program-counter unit, and otherwise
// the external source-read bus.
module mvdec_src_mux
    import mvdec_pkg::*;
(
    input  logic [UNIT_W-1:0] src_unit,
    input  logic [SUB_W-1:0]  src_sub,
    input  logic [WORD_W-1:0] pc,
    input  logic [WORD_W-1:0] src_rdata,
    output logic [WORD_W-1:0] data
);
    localparam int PAD_W = WORD_W - SUB_W;

    // Source selection by unit address.
    always_comb begin
        unique case (src_unit)
            UNIT_CONST: data = {{PAD_W{1'b0}}, src_sub};
            UNIT_PC:    data = pc;
            default:    data = src_rdata;
        endcase
    end
endmodule

// File: rtl/mvdec_pc.sv
// Module mvdec_pc
// Program-counter register. It loads a new value when a jump is signalled
// and otherwise advances by one each cycle. Synchronous active-low reset
// to zero.
module mvdec_pc
    import mvdec_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WORD_W-1:0] load_value,
    output logic [WORD_W-1:0] pc
);
    localparam logic [WORD_W-1:0] STEP = WORD_W'(1);

    // Counter update: jump target or sequential step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc <= '0;
        end else if (load) begin
            pc <= load_value;
        end else begin
            pc <= pc + STEP;
        end
    end
endmodule

// File: rtl/move_decoder.sv
// Module move_decoder
// Fetch and decode sequencer for a move-only processor. It runs one word
// per cycle. A long-constant prefix costs one extra fetch, during which no
// transfer is issued. Assumes instruction memory is read combinationally at
// imem_addr, and that src_rdata answers src_unit/src_sub in the same cycle.
module move_decoder
    import mvdec_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    output logic [WORD_W-1:0] imem_addr,
    input  logic [WORD_W-1:0] imem_rdata,
    input  logic [FLAG_W-1:0] flags,
    output logic [UNIT_W-1:0] src_unit,
    output logic [SUB_W-1:0]  src_sub,
    input  logic [WORD_W-1:0] src_rdata,
    output logic [UNIT_W-1:0] dst_unit,
    output logic [SUB_W-1:0]  dst_sub,
    output logic [WORD_W-1:0] move_data,
    output logic              move_en
);
    seq_state_e        state_q;
    seq_state_e        state_d;
    word_kind_e        kind;
    move_fields_t      fields;
    logic [WORD_W-1:0] short_value;
    logic [WORD_W-1:0] mux_data;
    logic              cond_pass;
    logic              issue;
    logic              pc_load;
    logic              in_long;

    mvdec_classify u_classify (
        .word        (imem_rdata),
        .kind        (kind),
        .fields      (fields),
        .short_value (short_value)
    );

    mvdec_cond u_cond (
        .flags (flags),
        .mask  (fields.mask),
        .match (fields.match),
        .pass  (cond_pass)
    );

    mvdec_src_mux u_src_mux (
        .src_unit  (fields.src_unit),
        .src_sub   (fields.src_sub),
        .pc        (imem_addr),
        .src_rdata (src_rdata),
        .data      (mux_data)
    );

    assign in_long = (state_q == SEQ_LONG);

    // Transfer selection per sequencer state and word kind.
    always_comb begin
        state_d   = SEQ_FETCH;
        src_unit  = fields.src_unit;
        src_sub   = fields.src_sub;
        dst_unit  = fields.dst_unit;
        dst_sub   = fields.dst_sub;
        move_data = mux_data;
        issue     = 1'b0;
        if (in_long) begin
            src_unit  = UNIT_CONST;
            src_sub   = SUB_ZERO;
            dst_unit  = UNIT_PC;
            dst_sub   = SUB_ZERO;
            move_data = imem_rdata;
            issue     = 1'b1;
        end else begin
            unique case (kind)
                WK_SHORT: begin
                    src_unit  = UNIT_CONST;
                    src_sub   = SUB_ZERO;
                    dst_unit  = UNIT_PC;
                    dst_sub   = SUB_ZERO;
                    move_data = short_value;
                    issue     = 1'b1;
                end
                WK_PREFIX: begin
                    state_d = SEQ_LONG;
                end
                default: begin
                    issue = cond_pass;
                end
            endcase
        end
    end

    assign move_en = issue & rst_n;
    assign pc_load = move_en && (dst_unit == UNIT_PC);

    mvdec_pc u_pc (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (pc_load),
        .load_value (move_data),
        .pc         (imem_addr)
    );

    // Sequencer state register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEQ_FETCH;
        end else begin
            state_q <= state_d;
        end
    end
endmodule

// File: rtl/move_decoder_chk.sv
// Module move_decoder_chk
// Property checker for move_decoder, attached by bind. It watches the
// ports and the sequencer's long-constant phase.
module move_decoder_chk
    import mvdec_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [WORD_W-1:0] imem_addr,
    input logic [WORD_W-1:0] imem_rdata,
    input logic [FLAG_W-1:0] flags,
    input logic [UNIT_W-1:0] dst_unit,
    input logic [WORD_W-1:0] move_data,
    input logic              move_en,
    input logic              in_long
);
    logic plain_move;
    assign plain_move = !in_long && !imem_rdata[WORD_W-1] && (imem_rdata != LONG_PREFIX);

    AST_RESET_STATE: assert property (@(posedge clk) !rst_n |=> (imem_addr == '0 && !in_long)); // R1
    AST_NO_MOVE_IN_RESET: assert property (@(posedge clk) !rst_n |-> !move_en); // R1
    AST_COND_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (plain_move && ((flags & imem_rdata[31:28]) != (imem_rdata[27:24] & imem_rdata[31:28]))) |-> !move_en); // R3
    AST_SHORT_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_long && imem_rdata[WORD_W-1]) |-> (move_en && move_data[WORD_W-1] == imem_rdata[WORD_W-2] && dst_unit == UNIT_PC)); // R4
    AST_PREFIX_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_long && imem_rdata == LONG_PREFIX) |-> !move_en); // R5
    AST_PREFIX_ENTERS_LONG: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_long && imem_rdata == LONG_PREFIX) |=> in_long); // R5
    AST_LONG_EXECUTES: assert property (@(posedge clk) disable iff (!rst_n)
        in_long |-> (move_en && move_data == imem_rdata && dst_unit == UNIT_PC)); // R5
    AST_LONG_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) in_long |=> !in_long); // R5
    AST_JUMP_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        (move_en && dst_unit == UNIT_PC) |=> (imem_addr == $past(move_data))); // R9
    AST_SEQ_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        !(move_en && dst_unit == UNIT_PC) |=> (imem_addr == $past(imem_addr) + 1)); // R9
endmodule

bind move_decoder move_decoder_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .imem_addr  (imem_addr),
    .imem_rdata (imem_rdata),
    .flags      (flags),
    .dst_unit   (dst_unit),
    .move_data  (move_data),
    .move_en    (move_en),
    .in_long    (in_long)
);

// File: tb/tb_move_decoder.sv
// Scoreboard bench for move_decoder: the driver task queues expected
// transfers and the monitor compares each strobed transfer in order.
module tb_move_decoder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] imem_addr;
    logic [31:0] imem_rdata;
    logic [3:0]  flags = 4'b1010;
    logic [7:0]  src_unit;
    logic [3:0]  src_sub;
    logic [31:0] src_rdata;
    logic [7:0]  dst_unit;
    logic [3:0]  dst_sub;
    logic [31:0] move_data;
    logic        move_en;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    typedef struct {
        logic [31:0] pc;
        logic [7:0]  su;
        logic [3:0]  ss;
        logic [7:0]  du;
        logic [3:0]  ds;
        logic [31:0] data;
        string       tag;
    } exp_t;

    exp_t exp_q[$];
    logic [31:0] imem [64];

    always #10 clk = ~clk;

    assign imem_rdata = imem[imem_addr[5:0]];

    function automatic logic [31:0] bus_value(input logic [7:0] u, input logic [3:0] s);
        return {8'hA5, u, 12'h000, s};
    endfunction

    assign src_rdata = bus_value(src_unit, src_sub);

    move_decoder dut (
        .clk(clk), .rst_n(rst_n), .imem_addr(imem_addr), .imem_rdata(imem_rdata),
        .flags(flags), .src_unit(src_unit), .src_sub(src_sub), .src_rdata(src_rdata),
        .dst_unit(dst_unit), .dst_sub(dst_sub), .move_data(move_data), .move_en(move_en)
    );

    task automatic expect_move(input logic [31:0] pc, input logic [7:0] su, input logic [3:0] ss,
                               input logic [7:0] du, input logic [3:0] ds, input logic [31:0] data,
                               input string tag);
        exp_t e;
        e.pc = pc; e.su = su; e.ss = ss; e.du = du; e.ds = ds; e.data = data; e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // Monitor: compare each strobed transfer with the head of the queue.
    always @(negedge clk) begin
        if (rst_n && move_en && exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            check(imem_addr == e.pc && src_unit == e.su && src_sub == e.ss &&
                  dst_unit == e.du && dst_sub == e.ds && move_data == e.data,
                  $sformatf("%s pc=%h su=%h ss=%h du=%h ds=%h", e.tag, imem_addr, src_unit, src_sub, dst_unit, dst_sub),
                  move_data, e.data);
        end
    end

    // Watchdog: a hung run counts as a failure.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 5000) begin
            errors++;
            $display("FAIL watchdog R10 actual=%0d expected=<5000", cycles);
            finish_run();
        end
    end

    initial begin
        for (int i = 0; i < 64; i++) imem[i] = 32'h0;
        imem[6'h00] = 32'h00A0_0023; // R6 constant unit nibble A
        imem[6'h01] = 32'h0043_5207; // R2 R8 bus source
        imem[6'h02] = 32'h4412_3456; // R3 mask 4 match 4, flag clear -> skipped
        imem[6'h03] = 32'h2212_3456; // R3 mask 2 match 2, flag set -> executes
        imem[6'h04] = 32'h8000_0010; // R4 short constant, jump to 0x10
        imem[6'h10] = 32'h0000_0F01; // R5 prefix
        imem[6'h11] = 32'h4400_0020; // R5 long value, condition-looking bits ignored
        imem[6'h20] = 32'h0000_1005; // R7 counter as source
        imem[6'h21] = 32'h44F0_0001; // R3 conditional jump not taken
        imem[6'h22] = 32'hFFFF_FFF0; // R4 negative short constant
        imem[6'h30] = 32'h00F0_0001; // R9 jump via constant unit to 0xF
        imem[6'h0F] = 32'h0000_1001; // R9 R10 self jump

        expect_move(32'h0,         8'h00, 4'hA, 8'h23, 4'h0, 32'h0000_000A, "R6");
        expect_move(32'h1,         8'h35, 4'h4, 8'h07, 4'h2, bus_value(8'h35, 4'h4), "R2_R8");
        expect_move(32'h3,         8'h23, 4'h1, 8'h56, 4'h4, bus_value(8'h23, 4'h1), "R3");
        expect_move(32'h4,         8'h00, 4'h0, 8'h01, 4'h0, 32'h0000_0010, "R4");
        expect_move(32'h11,        8'h00, 4'h0, 8'h01, 4'h0, 32'h4400_0020, "R5");
        expect_move(32'h4400_0020, 8'h01, 4'h0, 8'h05, 4'h0, 32'h4400_0020, "R7");
        expect_move(32'h4400_0022, 8'h00, 4'h0, 8'h01, 4'h0, 32'hFFFF_FFF0, "R4_neg");
        expect_move(32'hFFFF_FFF0, 8'h00, 4'hF, 8'h01, 4'h0, 32'h0000_000F, "R9");
        expect_move(32'hF,         8'h01, 4'h0, 8'h01, 4'h0, 32'h0000_000F, "R10");

        repeat (3) @(posedge clk);
        @(negedge clk);
        check(imem_addr == 32'h0, "R1 reset counter", imem_addr, 32'h0);
        check(move_en == 1'b0, "R1 strobe in reset", {31'h0, move_en}, 32'h0);
        @(posedge clk);
        #5 rst_n = 1'b1;

        while (exp_q.size() > 0) @(negedge clk);
        repeat (3) @(negedge clk);
        check(imem_addr == 32'hF, "R9 self jump holds counter", imem_addr, 32'hF);
        check(move_en == 1'b1, "R10 strobe on executed move", {31'h0, move_en}, 32'h1);

        rst_n = 1'b0;
        @(negedge clk);
        check(imem_addr == 32'h0, "R1 mid-run reset", imem_addr, 32'h0);
        check(move_en == 1'b0, "R1 strobe low after reset", {31'h0, move_en}, 32'h0);
        finish_run();
    end
endmodule